// File: doc/BRIEF.md
# DMT Subcarrier Frame Mapper

This block turns a serial payload bit stream into one 128-bin frequency-domain frame for a 128-point inverse FFT that makes a discrete multi-tone signal. A static mode input picks the constellation: QPSK, which takes 2 bits per symbol, or 16-QAM, which takes 4 bits per symbol. Fifty data symbols go on the low bins 1 to 50. Every other bin in the lower half is zero, and the upper half repeats the lower half as complex conjugates. The spectrum is therefore Hermitian-symmetric and the inverse transform gives a real time-domain signal.

The block first collects the bits of a whole frame and stores the 50 symbol codes. It then streams the 128 bins out in ascending order, one bin per accepted cycle. Each bin comes with its index, a valid flag and start/end-of-frame markers, under ready/valid flow control. While a frame is being emitted the block does not accept bits. Bits offered in that time wait upstream and are not lost.

Top module: `dmt_frame_mapper`

## Requirements
- R1: After reset, and whenever reset is applied again (even part way through collecting a frame), `out_valid` is low and `bits_ready` is high. A partly collected frame is discarded.
- R2: A frame takes exactly 100 bits in QPSK mode and 200 bits in 16-QAM mode. `bits_ready` is low whenever `out_valid` is high, so no bit is taken while a frame is being emitted.
- R3: The bins of a frame come out with `out_bin` = 0, 1, …, 127 in order. `out_sof` is high only on bin 0 and `out_eof` only on bin 127. After bin 127 is accepted, `out_valid` drops.
- R4: Bin 0 and bins 51 to 77 (this covers the Nyquist bin 64) carry zero in both `out_re` and `out_im`.
- R5: The bits are used in arrival order. Symbol j (0 to 49) sits on bin j+1 and uses bits j·B to j·B+B−1, where B is the number of bits per symbol. The first bit of the frame is the most significant bit of bin 1's symbol.
- R6: In QPSK mode (`mode_qam16`=0) the first bit of a symbol sets the real part and the second sets the imaginary part. A bit of 1 gives +3·UNIT and a bit of 0 gives −3·UNIT (UNIT defaults to 256).
- R7: In 16-QAM mode (`mode_qam16`=1), bits 1–2 of a symbol set the real part and bits 3–4 set the imaginary part. Each pair is Gray-coded as 00→−3·UNIT, 01→−1·UNIT, 11→+1·UNIT, 10→+3·UNIT.
- R8: For k = 1 to 50, bin 128−k has the same real part as bin k and the negated imaginary part.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_bin`, `out_re` and `out_im` hold their values in the next cycle.
- R10: Cycles in which `bits_valid` is low consume nothing and do not change the frame that results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_qam16 | input | 1 | Constellation select: 0 QPSK, 1 16-QAM (static) |
| bits_in | input | 1 | Payload bit |
| bits_valid | input | 1 | Payload bit is present |
| bits_ready | output | 1 | Block takes a bit this cycle if valid |
| out_valid | output | 1 | Bin output is valid |
| out_ready | input | 1 | Downstream accepts the bin |
| out_bin | output | 7 | Bin index 0..127 |
| out_re | output | 12 | Real part, signed |
| out_im | output | 12 | Imaginary part, signed |
| out_sof | output | 1 | First bin of frame |
| out_eof | output | 1 | Last bin of frame |

## Verification
A wrong bit or symbol counter in the collector moves every later symbol by one position. That error shows at the ports on bin 1 or bin 2 of the same frame. It also shows up in the mirror bins, because the bench checks each of them against its own bits. A bad bin counter shows at once as a skipped index or a misplaced `out_sof`/`out_eof`. A state bit that lets bits in during emission shows as `bits_ready` high together with `out_valid`, and the frame after it is then shifted. Under stall patterns the bench checks that a held bin is unchanged on the very next cycle.

// File: rtl/dmt_map_pkg.sv
package dmt_map_pkg;
    localparam int unsigned CODE_W = 4;
    typedef logic [CODE_W-1:0] sym_code_t;
endpackage

// File: rtl/dmt_bit_packer.sv
module dmt_bit_packer
    import dmt_map_pkg::*;
#(
    parameter int unsigned N_DATA = 50,
    localparam int unsigned SYM_W = $clog2(N_DATA)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qam16,
    input  logic             bit_in,
    input  logic             bit_valid,
    input  logic             frame_done,
    output logic             bit_ready,
    output logic             wr_en,
    output logic [SYM_W-1:0] wr_addr,
    output sym_code_t        wr_code,
    output logic             frame_full
);
    localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(N_DATA - 1);

    typedef struct packed {
        logic             collecting;
        logic [1:0]       bit_cnt;
        logic [SYM_W-1:0] sym_cnt;
        logic [2:0]       shift;
    } pk_state_t;

    pk_state_t st_d, st_q;
    logic      take;
    logic      last_bit;

    always_comb begin
        st_d       = st_q;
        wr_en      = 1'b0;
        frame_full = 1'b0;
        take       = st_q.collecting & bit_valid;
        last_bit   = qam16 ? (st_q.bit_cnt == 2'd3) : (st_q.bit_cnt == 2'd1);
        wr_addr    = st_q.sym_cnt;
        wr_code    = {st_q.shift, bit_in};
        if (take) begin
            st_d.shift = {st_q.shift[1:0], bit_in};
            if (last_bit) begin
                st_d.bit_cnt = 2'd0;
                wr_en        = 1'b1;
                if (st_q.sym_cnt == LAST_SYM) begin
                    st_d.sym_cnt    = '0;
                    st_d.collecting = 1'b0;
                    frame_full      = 1'b1;
                end else begin
                    st_d.sym_cnt = st_q.sym_cnt + 1'b1;
                end
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + 1'b1;
            end
        end
        if (frame_done) begin
            st_d.collecting = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{collecting: 1'b1, bit_cnt: 2'd0, sym_cnt: '0, shift: 3'd0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_ready = st_q.collecting;
endmodule

// File: rtl/dmt_symbol_store.sv
module dmt_symbol_store
    import dmt_map_pkg::*;
#(
    parameter int unsigned N_DATA = 50,
    localparam int unsigned SYM_W = $clog2(N_DATA)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SYM_W-1:0] wr_addr,
    input  sym_code_t        wr_code,
    input  logic [SYM_W-1:0] rd_addr,
    output sym_code_t        rd_code
);
    sym_code_t slot_q [N_DATA];

    for (genvar g = 0; g < N_DATA; g++) begin : g_slot
        sym_code_t slot_d;
        always_comb begin
            slot_d = slot_q[g];
            if (wr_en && (wr_addr == SYM_W'(g))) begin
                slot_d = wr_code;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else begin
                slot_q[g] <= slot_d;
            end
        end
    end

    always_comb begin
        rd_code = '0;
        if (int'(rd_addr) < N_DATA) begin
            rd_code = slot_q[rd_addr];
        end
    end
endmodule

// File: rtl/dmt_bin_sequencer.sv
module dmt_bin_sequencer #(
    parameter int unsigned N_FFT = 128,
    localparam int unsigned IDX_W = $clog2(N_FFT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_bin,
    output logic             out_sof,
    output logic             out_eof,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(N_FFT - 1);

    typedef struct packed {
        logic             emitting;
        logic [IDX_W-1:0] idx;
    } sq_state_t;

    sq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start) begin
            st_d.emitting = 1'b1;
            st_d.idx      = '0;
        end
        if (st_q.emitting && out_ready) begin
            if (st_q.idx == LAST_BIN) begin
                st_d.emitting = 1'b0;
                done          = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{emitting: 1'b0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.emitting;
    assign out_bin   = st_q.idx;
    assign out_sof   = st_q.emitting && (st_q.idx == '0);
    assign out_eof   = st_q.emitting && (st_q.idx == LAST_BIN);
endmodule

// File: rtl/dmt_bin_mapper.sv
module dmt_bin_mapper
    import dmt_map_pkg::*;
#(
    parameter int unsigned N_FFT  = 128,
    parameter int unsigned N_DATA = 50,
    parameter int unsigned COMP_W = 12,
    parameter int unsigned UNIT   = 256,
    localparam int unsigned IDX_W = $clog2(N_FFT),
    localparam int unsigned SYM_W = $clog2(N_DATA)
) (
    input  logic                     qam16,
    input  logic [IDX_W-1:0]         bin_idx,
    input  sym_code_t                rd_code,
    output logic [SYM_W-1:0]         rd_addr,
    output logic signed [COMP_W-1:0] re,
    output logic signed [COMP_W-1:0] im
);
    localparam logic signed [COMP_W-1:0] LV1 = COMP_W'(UNIT);
    localparam logic signed [COMP_W-1:0] LV3 = COMP_W'(3 * UNIT);

    function automatic logic signed [COMP_W-1:0] axis_level(
        input logic qam, input logic sgn, input logic inner);
        logic signed [COMP_W-1:0] mag;
        mag = (qam && inner) ? LV1 : LV3;
        return sgn ? mag : -mag;
    endfunction

    int   k;
    logic in_low;
    logic in_high;
    logic signed [COMP_W-1:0] sym_re;
    logic signed [COMP_W-1:0] sym_im;

    always_comb begin
        k       = int'(bin_idx);
        in_low  = (k >= 1) && (k <= int'(N_DATA));
        in_high = (k >= int'(N_FFT - N_DATA));
        rd_addr = in_low ? SYM_W'(k - 1) : SYM_W'(int'(N_FFT) - 1 - k);
        if (qam16) begin
            sym_re = axis_level(1'b1, rd_code[3], rd_code[2]);
            sym_im = axis_level(1'b1, rd_code[1], rd_code[0]);
        end else begin
            sym_re = axis_level(1'b0, rd_code[1], 1'b0);
            sym_im = axis_level(1'b0, rd_code[0], 1'b0);
        end
        re = '0;
        im = '0;
        if (in_low) begin
            re = sym_re;
            im = sym_im;
        end else if (in_high) begin
            re = sym_re;
            im = -sym_im;
        end
    end
endmodule

// File: rtl/dmt_frame_mapper.sv
module dmt_frame_mapper
    import dmt_map_pkg::*;
#(
    parameter int unsigned N_FFT  = 128,
    parameter int unsigned N_DATA = 50,
    parameter int unsigned COMP_W = 12,
    parameter int unsigned UNIT   = 256,
    localparam int unsigned IDX_W = $clog2(N_FFT)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_qam16,
    input  logic                     bits_in,
    input  logic                     bits_valid,
    output logic                     bits_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [IDX_W-1:0]         out_bin,
    output logic signed [COMP_W-1:0] out_re,
    output logic signed [COMP_W-1:0] out_im,
    output logic                     out_sof,
    output logic                     out_eof
);
    localparam int unsigned SYM_W = $clog2(N_DATA);

    logic             wr_en;
    logic [SYM_W-1:0] wr_addr;
    sym_code_t        wr_code;
    logic [SYM_W-1:0] rd_addr;
    sym_code_t        rd_code;
    logic             frame_full;
    logic             frame_done;

    dmt_bit_packer #(.N_DATA(N_DATA)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .qam16      (mode_qam16),
        .bit_in     (bits_in),
        .bit_valid  (bits_valid),
        .frame_done (frame_done),
        .bit_ready  (bits_ready),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_code    (wr_code),
        .frame_full (frame_full)
    );

    dmt_symbol_store #(.N_DATA(N_DATA)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_code (wr_code),
        .rd_addr (rd_addr),
        .rd_code (rd_code)
    );

    dmt_bin_sequencer #(.N_FFT(N_FFT)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_full),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_bin   (out_bin),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .done      (frame_done)
    );

    dmt_bin_mapper #(
        .N_FFT (N_FFT),
        .N_DATA(N_DATA),
        .COMP_W(COMP_W),
        .UNIT  (UNIT)
    ) u_map (
        .qam16   (mode_qam16),
        .bin_idx (out_bin),
        .rd_code (rd_code),
        .rd_addr (rd_addr),
        .re      (out_re),
        .im      (out_im)
    );
endmodule

// File: rtl/dmt_frame_mapper_chk.sv
module dmt_frame_mapper_chk #(
    parameter int unsigned IDX_W  = 7,
    parameter int unsigned COMP_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bits_ready,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [IDX_W-1:0]         out_bin,
    input logic signed [COMP_W-1:0] out_re,
    input logic signed [COMP_W-1:0] out_im,
    input logic                     out_eof
);
    p_no_bits_while_emit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !bits_ready);

    p_bin_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_eof) |=>
            (out_valid && out_bin == IDX_W'($past(out_bin) + 1'b1)));

    p_eof_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eof) |=> !out_valid);

    p_dc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == '0) |-> (out_re == '0 && out_im == '0));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_bin) && $stable(out_re) && $stable(out_im)));
endmodule

bind dmt_frame_mapper dmt_frame_mapper_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bits_ready (bits_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_bin    (out_bin),
    .out_re     (out_re),
    .out_im     (out_im),
    .out_eof    (out_eof)
);

// File: tb/sim_dmt_frame_mapper.sv
`timescale 1ns/1ps
module sim_dmt_frame_mapper;
    localparam int UNIT = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_qam16 = 1'b0;
    logic bits_in = 1'b0;
    logic bits_valid = 1'b0;
    logic bits_ready;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [6:0] out_bin;
    logic signed [11:0] out_re;
    logic signed [11:0] out_im;
    logic out_sof;
    logic out_eof;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    logic frame_bits [200];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dmt_frame_mapper u0 (
        .clk(clk), .rst_n(rst_n), .mode_qam16(mode_qam16),
        .bits_in(bits_in), .bits_valid(bits_valid), .bits_ready(bits_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_bin(out_bin),
        .out_re(out_re), .out_im(out_im), .out_sof(out_sof), .out_eof(out_eof)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int axis(input logic qam, input logic s, input logic m);
        int mag;
        mag = (qam && m) ? UNIT : 3 * UNIT;
        return s ? mag : -mag;
    endfunction

    function automatic void exp_bin(input logic qam, input int k, output int er, output int ei);
        int j;
        int off;
        bit hi;
        er = 0; ei = 0;
        hi = 1'b0;
        if (k >= 1 && k <= 50) j = k - 1;
        else if (k >= 78) begin j = 127 - k; hi = 1'b1; end
        else return;
        if (qam) begin
            off = 4 * j;
            er = axis(1'b1, frame_bits[off], frame_bits[off+1]);
            ei = axis(1'b1, frame_bits[off+2], frame_bits[off+3]);
        end else begin
            off = 2 * j;
            er = axis(1'b0, frame_bits[off], 1'b0);
            ei = axis(1'b0, frame_bits[off+1], 1'b0);
        end
        if (hi) ei = -ei;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        bits_valid = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(bits_ready == 1'b1, "R1 bits_ready after reset", int'(bits_ready), 1);
    endtask

    // One full frame; stall_mode picks output backpressure, gap_mode input gaps.
    task automatic run_frame(input logic qam, input int seed, input int stall_mode, input int gap_mode);
        int nb;
        int bp;
        int k;
        int extra;
        int overlap;
        int frame_err;
        int er;
        int ei;
        int guard;
        bit hold;
        int h_bin;
        int h_re;
        int h_im;
        logic [15:0] lf;
        string tag;
        nb = qam ? 200 : 100;
        lf = 16'(seed) | 16'h1;
        for (int i = 0; i < 200; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            frame_bits[i] = lf[0];
        end
        mode_qam16 = qam;
        bp = 0; k = 0; extra = 0; overlap = 0; frame_err = 0; guard = 0; hold = 1'b0;
        h_bin = 0; h_re = 0; h_im = 0;
        while (k < 128 && guard < 4000) begin
            @(negedge clk);
            guard++;
            if (hold) begin
                chk(out_valid && int'(out_bin) == h_bin && int'(out_re) == h_re && int'(out_im) == h_im,
                    "R9 held bin changed", int'(out_bin), h_bin);
                hold = 1'b0;
            end
            if (bp < nb) begin
                bits_valid = (gap_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
                bits_in = frame_bits[bp];
            end else begin
                bits_valid = 1'b1;
                bits_in = 1'b1;
            end
            case (stall_mode)
                0: out_ready = 1'b1;
                1: out_ready = ((cyc % 3) != 1);
                default: out_ready = ((cyc % 7) < 2);
            endcase
            #1;
            if (out_valid && bits_ready) overlap++;
            if (bits_valid && bits_ready) begin
                if (bp < nb) bp++;
                else extra++;
            end
            if (out_valid) begin
                if (out_ready) begin
                    exp_bin(qam, k, er, ei);
                    if (k == 0 || (k >= 51 && k <= 77)) tag = "R4 zero bin";
                    else if (k == 1) tag = "R5 first symbol";
                    else if (k <= 50) tag = qam ? "R7 qam16 bin" : "R6 qpsk bin";
                    else tag = "R8 mirror bin";
                    chk(int'(out_bin) == k, "R3 bin order", int'(out_bin), k);
                    chk(out_sof == (k == 0), "R3 sof", int'(out_sof), int'(k == 0));
                    chk(out_eof == (k == 127), "R3 eof", int'(out_eof), int'(k == 127));
                    if (int'(out_re) != er || int'(out_im) != ei) frame_err++;
                    chk(int'(out_re) == er, {tag, " re"}, int'(out_re), er);
                    chk(int'(out_im) == ei, {tag, " im"}, int'(out_im), ei);
                    k++;
                end else begin
                    hold = 1'b1;
                    h_bin = int'(out_bin); h_re = int'(out_re); h_im = int'(out_im);
                end
            end
        end
        chk(guard < 4000, "R3 frame timeout", guard, 4000);
        @(negedge clk);
        bits_valid = 1'b0;
        out_ready = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R3 valid drops after eof", int'(out_valid), 0);
        chk(bp == nb, "R2 bits per frame", bp, nb);
        chk(extra == 0, "R2 bits taken during emission", extra, 0);
        chk(overlap == 0, "R2 bits_ready with out_valid", overlap, 0);
        if (gap_mode != 0) chk(frame_err == 0, "R10 frame with input gaps", frame_err, 0);
    endtask

    task automatic reset_midframe();
        mode_qam16 = 1'b1;
        for (int i = 0; i < 37; i++) begin
            @(negedge clk);
            bits_valid = 1'b1;
            bits_in = i[0];
        end
        @(negedge clk);
        bits_valid = 1'b0;
        do_reset();
        run_frame(1'b1, 16'h5a5a, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        run_frame(1'b0, 16'h1234, 0, 0);
        run_frame(1'b0, 16'hbeef, 1, 1);
        run_frame(1'b1, 16'h0f0f, 0, 0);
        run_frame(1'b1, 16'h7777, 2, 1);
        run_frame(1'b1, 16'hc3c3, 1, 0);
        reset_midframe();
        run_frame(1'b0, 16'h2468, 2, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule